// File: doc/BRIEF.md
# I2C Byte-Streaming Master

This block is a single-master I2C engine for an open-drain two-wire bus. On a rising request it issues a START, sends the 7-bit target address with the direction bit, and then moves data bytes one at a time for as long as the request stays high. When the request drops, or when the target refuses a byte, it closes the transfer with a STOP. The serial clock comes from a divided system clock. Each bit period has four quarter phases. SDA changes in the middle of the SCL low time, and the line is sampled in the middle of the SCL high time.

The caller streams data through a byte-boundary strobe. One clock after the eighth bit of every byte, including the address byte, the block raises a one-cycle load strobe. In write mode the caller then places the next byte on the write-data input. In read mode it collects the byte just received from the read-data output. Either way, it lowers the request to end the transfer after the current byte. Neither line is ever driven high: each output only asks for its line to be pulled low.

Top module: `i2c_stream_master`

## Requirements
- R1: During and after reset, with the request low, busy, load strobe and error flag are 0, and neither line is pulled low.
- R2: A request seen while idle raises busy. The transfer opens with SDA pulled low while SCL stays released (a START). Busy rises with both lines released.
- R3: Outside START and STOP, SDA changes only while SCL is low. Only START pulls SDA low while SCL is high, and only STOP releases SDA while SCL is high.
- R4: The first byte after START is the 7-bit address (bits 7..1) followed by the direction bit in bit 0: 0 means the master writes and 1 means the master reads. Every byte is sent most significant bit first.
- R5: One SCL period is 4 × SYS_CLK_HZ/(4 × SCL_HZ) system clocks. The default SCL_HZ is 10 kHz, and the parameter is meant for rates of 100 kHz or lower.
- R6: A one-cycle load strobe follows the eighth bit of every byte, the address byte included. In write mode the next data byte is taken from the write-data input at the end of the acknowledge bit.
- R7: If the target leaves SDA high during the acknowledge bit of a byte the master sent, the error flag sets and a STOP follows with no further byte. The flag holds until the next START.
- R8: While the request stays high, write bytes keep streaming. The transfer ends with STOP after the first byte whose acknowledge completes with the request low.
- R9: In read mode the received byte is on the read-data output by the time of its load strobe. The master pulls SDA low for the acknowledge if the request is high at the start of the acknowledge bit, and otherwise leaves it high (NACK) and then sends STOP.
- R10: Busy falls only after STOP has released SDA with SCL high. Whenever busy is low, both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ena_i | input | 1 | Request: start a transfer, and hold it open while high |
| addr_i | input | 7 | Target address |
| rw_i | input | 1 | Direction bit: 0 write, 1 read |
| wdata_i | input | 8 | Next byte to send |
| rdata_o | output | 8 | Last byte received |
| busy_o | output | 1 | Transfer in progress |
| load_o | output | 1 | One-cycle byte-boundary strobe |
| ack_err_o | output | 1 | Target refused a byte |
| scl_low_o | output | 1 | Pull SCL low when 1 |
| sda_low_o | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Resolved SDA level |

## Verification
With a quarter of 10 clocks, a bit lasts 40 clocks. The load strobe comes one clock after the rising edge that ends a byte's eighth bit, and the bench reacts to it on the next falling clock edge. That leaves the caller 10 clocks before the request is sampled at the start of the acknowledge bit, and 40 clocks before the next write byte is taken. The read data is checked at the strobe, which falls at least a quarter after the capture. A target model that watches the bus edges measures the SCL period, and every other result is compared only after busy has fallen, when no change is still on its way.

// File: rtl/i2c_stream_pkg.sv
package i2c_stream_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_ACK,
    ST_STOP
  } state_e;
endpackage

// File: rtl/i2c_phase_gen.sv
module i2c_phase_gen #(
  parameter int unsigned QTR = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  output logic       tick_o,
  output logic [1:0] phase_o
);
  localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(QTR - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= 2'd0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_o <= 2'd0;
    end else if (tick_o) begin
      cnt_q   <= '0;
      phase_o <= phase_o + 2'd1;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/i2c_shreg.sv
module i2c_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         sin_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= load_val_i;
    else if (shift_i) q_o <= {q_o[W-2:0], sin_i};
  end
endmodule

// File: rtl/i2c_stream_master.sv
module i2c_stream_master
  import i2c_stream_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 200_000_000,
  parameter int unsigned SCL_HZ     = 10_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ena_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rw_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              load_o,
  output logic              ack_err_o,
  output logic              scl_low_o,
  output logic              sda_low_o,
  input  logic              sda_i
);
  localparam int unsigned QTR    = SYS_CLK_HZ / (4 * SCL_HZ);
  localparam int          BIT_CW = $clog2(BYTE_W);

  state_e              state_q;
  logic                tick;
  logic [1:0]          phase;
  logic                rw_q, first_q, ack_bad_q, ack_sent_q, cap_q;
  logic [BIT_CW-1:0]   bit_cnt_q;
  logic [BYTE_W-1:0]   tx_q, rx_q, tx_val;
  logic                tx_mode, ack_go, tx_load, tx_shift, rx_shift;
  logic                in_start_w, in_stop_w;

  assign busy_o     = (state_q != ST_IDLE);
  assign tx_mode    = first_q | ~rw_q;
  assign in_start_w = (state_q == ST_START);
  assign in_stop_w  = (state_q == ST_STOP);
  // SCL is low in the first half of every bit and of STOP
  assign scl_low_o  = (state_q == ST_BIT || state_q == ST_ACK || state_q == ST_STOP)
                      && !phase[1];

  always_comb begin
    ack_go   = tx_mode ? (!ack_bad_q && ena_i) : ack_sent_q;
    tx_val   = (state_q == ST_IDLE) ? {addr_i, rw_i} : wdata_i;
    tx_load  = (state_q == ST_IDLE && ena_i) ||
               (state_q == ST_ACK && tick && phase == 2'd3 && ack_go && !rw_q);
    tx_shift = (state_q == ST_BIT) && tick && (phase == 2'd3);
    rx_shift = (state_q == ST_BIT) && tick && (phase == 2'd2) && !tx_mode;
  end

  i2c_phase_gen #(.QTR(QTR)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (busy_o),
    .tick_o  (tick),
    .phase_o (phase)
  );

  i2c_shreg #(.W(BYTE_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tx_load),
    .load_val_i (tx_val),
    .shift_i    (tx_shift),
    .sin_i      (1'b0),
    .q_o        (tx_q)
  );

  i2c_shreg #(.W(BYTE_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (1'b0),
    .load_val_i ('0),
    .shift_i    (rx_shift),
    .sin_i      (sda_i),
    .q_o        (rx_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rw_q       <= 1'b0;
      first_q    <= 1'b0;
      ack_bad_q  <= 1'b0;
      ack_sent_q <= 1'b0;
      cap_q      <= 1'b0;
      bit_cnt_q  <= '0;
      sda_low_o  <= 1'b0;
      load_o     <= 1'b0;
      ack_err_o  <= 1'b0;
      rdata_o    <= '0;
    end else begin
      load_o <= 1'b0;
      cap_q  <= 1'b0;
      if (cap_q) rdata_o <= rx_q;
      unique case (state_q)
        ST_IDLE: if (ena_i) begin
          state_q   <= ST_START;
          rw_q      <= rw_i;
          first_q   <= 1'b1;
          ack_err_o <= 1'b0;
        end
        ST_START: if (tick) begin
          if (phase == 2'd1) sda_low_o <= 1'b1;   // falls with SCL high
          if (phase == 2'd3) begin
            state_q   <= ST_BIT;
            bit_cnt_q <= '0;
          end
        end
        ST_BIT: if (tick) begin
          if (phase == 2'd0) sda_low_o <= tx_mode & ~tx_q[BYTE_W-1];
          if (phase == 2'd2 && !tx_mode && bit_cnt_q == BIT_CW'(BYTE_W - 1))
            cap_q <= 1'b1;
          if (phase == 2'd3) begin
            if (bit_cnt_q == BIT_CW'(BYTE_W - 1)) begin
              state_q <= ST_ACK;
              load_o  <= 1'b1;
            end else begin
              bit_cnt_q <= bit_cnt_q + BIT_CW'(1);
            end
          end
        end
        ST_ACK: if (tick) begin
          if (phase == 2'd0) begin
            sda_low_o  <= !tx_mode && ena_i;
            ack_sent_q <= ena_i;
          end
          if (phase == 2'd2) ack_bad_q <= sda_i;
          if (phase == 2'd3) begin
            first_q   <= 1'b0;
            bit_cnt_q <= '0;
            if (tx_mode && ack_bad_q) ack_err_o <= 1'b1;
            state_q <= ack_go ? ST_BIT : ST_STOP;
          end
        end
        ST_STOP: if (tick) begin
          if (phase == 2'd0) sda_low_o <= 1'b1;
          if (phase == 2'd2) sda_low_o <= 1'b0;   // rises with SCL high
          if (phase == 2'd3) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_stream_master_chk.sv
module i2c_stream_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_low_o,
  input logic sda_low_o,
  input logic busy_o,
  input logic load_o,
  input logic ack_err_o,
  input logic in_start_i,
  input logic in_stop_i
);
  assert_start_only_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_low_o && !$past(scl_low_o) && sda_low_o && !$past(sda_low_o)) |-> in_start_i);

  assert_stop_only_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_low_o && !$past(scl_low_o) && !sda_low_o && $past(sda_low_o)) |-> in_stop_i);

  assert_busy_rise_released_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!scl_low_o && !sda_low_o));

  assert_load_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);

  assert_load_in_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> busy_o);

  assert_err_in_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_err_o) |-> busy_o);

  assert_idle_released_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_low_o && !sda_low_o));
endmodule

bind i2c_stream_master i2c_stream_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_low_o  (scl_low_o),
  .sda_low_o  (sda_low_o),
  .busy_o     (busy_o),
  .load_o     (load_o),
  .ack_err_o  (ack_err_o),
  .in_start_i (in_start_w),
  .in_stop_i  (in_stop_w)
);

// File: tb/i2c_stream_master_test.sv
`timescale 1ns/1ps
module i2c_stream_master_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       ena = 1'b0, rw = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       busy, load, err, scl_low, sda_low;
  logic       sl_low = 1'b0;
  logic       scl_bus, sda_bus;

  assign scl_bus = ~scl_low;
  assign sda_bus = ~(sda_low | sl_low);

  i2c_stream_master #(.SYS_CLK_HZ(400_000), .SCL_HZ(10_000)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ena_i(ena), .addr_i(addr), .rw_i(rw),
    .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy), .load_o(load),
    .ack_err_o(err), .scl_low_o(scl_low), .sda_low_o(sda_low), .sda_i(sda_bus)
  );

  typedef struct packed {
    logic [6:0] addr;
    logic       rw;
    logic [1:0] n;     // data bytes
    logic [7:0] d0;
    logic [3:0] nk;    // byte index the target refuses, 15 = none
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{7'h50, 1'b0, 2'd2, 8'hA5, 4'hF},
    '{7'h7F, 1'b0, 2'd1, 8'h00, 4'hF},
    '{7'h28, 1'b1, 2'd3, 8'h3C, 4'hF},
    '{7'h01, 1'b1, 2'd1, 8'hFF, 4'hF},
    '{7'h50, 1'b0, 2'd3, 8'h12, 4'h0},
    '{7'h55, 1'b0, 2'd3, 8'h81, 4'h2}
  };

  function automatic logic [7:0] exp_byte(logic [7:0] d0, int j);
    return d0 + 8'(j * 55);
  endfunction

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // target model on the bus
  logic [3:0] nack_at = 4'hF;
  logic [7:0] rd_d0 = '0;
  int cyc = 0, seen = 0, byte_idx = 0, n_start = 0, n_stop = 0, n_tx = 0;
  int last_rise = 0, last_period = 0;
  logic scl_prev = 1'b1, sda_prev = 1'b1, rw_s = 1'b0;
  logic [7:0] shreg = '0;
  logic [7:0] slog [8];
  logic       mack [8];

  always @(negedge clk) begin
    cyc++;
    if (scl_bus && scl_prev && sda_prev && !sda_bus) begin
      n_start++; seen = 0; byte_idx = 0; sl_low = 1'b0;
    end else if (scl_bus && scl_prev && !sda_prev && sda_bus) begin
      n_stop++;
    end else if (scl_bus && !scl_prev) begin
      last_period = cyc - last_rise;
      last_rise = cyc;
      if (seen < 8) shreg = {shreg[6:0], sda_bus};
      else if (byte_idx < 8) mack[byte_idx] = !sda_bus;
      seen++;
    end else if (!scl_bus && scl_prev) begin
      if (seen == 8) begin
        if (byte_idx == 0) rw_s = shreg[0];
        if (byte_idx == 0 || !rw_s) begin
          if (byte_idx < 8) slog[byte_idx] = shreg;
          n_tx++;
          sl_low = (4'(byte_idx) != nack_at);
        end else sl_low = 1'b0;
      end else if (seen == 9) begin
        sl_low = 1'b0;
        if (rw_s && ((byte_idx == 0 && nack_at != 4'h0) ||
                     (byte_idx > 0 && byte_idx < 8 && mack[byte_idx])))
          sl_low = !exp_byte(rd_d0, byte_idx + 1)[7];
        seen = 0;
        byte_idx++;
      end else if (seen >= 1 && seen <= 7 && rw_s && byte_idx > 0) begin
        sl_low = !exp_byte(rd_d0, byte_idx)[7 - seen];
      end
    end
    scl_prev = scl_bus;
    sda_prev = sda_bus;
  end

  task automatic run_vec(vec_t v);
    int b_start = n_start, b_stop = n_stop, b_tx = n_tx;
    int loads = 0, guard = 0;
    bit exp_err;
    int exp_cnt;
    nack_at = v.nk; rd_d0 = v.d0;
    addr = v.addr; rw = v.rw; wdata = 8'h00; ena = 1'b1;
    while (!busy && guard < 1000) begin @(negedge clk); guard++; end
    check("R2 busy at request", busy, 1);
    while (busy && guard < 20000) begin
      @(negedge clk); guard++;
      if (load) begin
        if (v.rw && loads >= 1)
          check("R9 read data at strobe", rdata, exp_byte(v.d0, loads));
        if (loads >= int'(v.n)) ena = 1'b0;
        else wdata = exp_byte(v.d0, loads + 1);
        loads++;
      end
    end
    ena = 1'b0;
    exp_err = (int'(v.nk) <= int'(v.n)) && (v.nk == 4'h0 || !v.rw);
    exp_cnt = exp_err ? int'(v.nk) + 1 : int'(v.n) + 1;
    check("R7 error flag", err, exp_err);
    check("R6 load strobes", loads, exp_cnt);
    check("R4 address byte", slog[0], {v.addr, v.rw});
    check("R8 bytes sent", n_tx - b_tx, v.rw ? 1 : exp_cnt);
    if (!v.rw)
      for (int j = 1; j < exp_cnt; j++)
        check("R8 write byte", slog[j], exp_byte(v.d0, j));
    if (v.rw && !exp_err)
      for (int j = 1; j <= int'(v.n); j++)
        check("R9 master ack", mack[j], (j < int'(v.n)) ? 1 : 0);
    check("R2 one START", n_start - b_start, 1);
    check("R10 one STOP", n_stop - b_stop, 1);
    check("R10 lines released", {scl_low, sda_low}, 0);
    check("R5 SCL period", last_period, 40);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {busy, load, err, scl_low, sda_low}, 0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    check("R1 idle without request", {busy, load, err, scl_low, sda_low}, 0);
    check("R1 no START when idle", n_start, 0);
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);
    check("R7 error held until next START", err, 1);
    run_vec('{7'h3A, 1'b0, 2'd1, 8'h66, 4'hF});
    check("R7 error cleared by new START", err, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule